// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target side of a four-wire in-system programming link. An external programmer drives a serial clock, a data line into the target and a mode-control pin. The target shifts back data on its own serial output. All logic runs on the system clock. The serial clock, the input data line and the mode pin are synchronised, and the serial clock is edge-detected. Every 32 received bits form one instruction frame, which the block decodes and executes against a register-array model of paged program memory and byte-wide data memory.

Program memory is written in two steps. Words are first staged in a page buffer, one byte at a time. A commit instruction then copies the whole buffer into one page. Commits, data-memory writes and chip erase each start a write-busy interval that lasts a fixed number of system clocks. During that interval, reads that fall inside the page being written return 0xFF. There is no data stream at the block's edge, so the serial pins and the mode flag are plain signals. The programmer paces the link by holding each serial-clock level for at least 8 system clocks. Each level must last that long because the output byte for the next slot is loaded a few clocks after a rising edge, and that load has to finish before the following falling edge.

Top module: `isp_target`

## Requirements
- R1: A frame is exactly 32 bits. The input line is sampled on each rising serial-clock edge, MSB first. An instruction acts only once its 32nd bit is in. Frames that do not decode are consumed whole and change nothing.
- R2: The serial output changes only after a falling serial-clock edge. During the first byte slot of a frame it sends 0x00. During slots 1 and 2 it sends back the byte received in the previous slot. So, in sync, the enable frame returns 0x53 while its third byte is being received.
- R3: Frame bytes 0xAC, 0x53, x, x enable programming mode, and the mode flag goes high. While the target is outside the mode, no other frame changes any state, and that includes an enable frame whose second byte is not 0x53.
- R4: Opcode 0x40 stages the low data byte and opcode 0x48 stages the high data byte of one page-buffer word. The word is selected by the low page-index bits of byte 2, and byte 3 carries the data.
- R5: Opcode 0x4C commits the page buffer to the page selected by word address {byte1, byte2} with its page-offset bits dropped. After the commit, every buffer word reads as 0xFFFF, so a later commit of an unloaded buffer erases the page.
- R6: Opcode 0x20 returns the low byte and opcode 0x28 returns the high byte of program word {byte1, byte2}, during the fourth byte slot.
- R7: Commit, data write and chip erase each hold the block busy for BUSY_CYCLES system clocks. While the block is busy, every instruction except a read is ignored.
- R8: While a commit is busy, a read of any word in the committed page returns 0xFF, and reads of other pages return stored data. Once busy ends, the committed values are returned.
- R9: Frame bytes 0xAC, 0x80, x, x set every program word to 0xFFFF and every data byte to 0xFF.
- R10: Opcode 0xC0 replaces the data byte at address byte 2 with byte 3, whatever the old value was. Opcode 0xA0 returns the byte at address byte 2 during the fourth slot.
- R11: A high level on the mode pin leaves programming mode, discards a partial frame and drives the serial output low. A new enable frame is then needed.
- R12: After system reset, every program word reads 0xFFFF, every data byte reads 0xFF, the mode flag is low and the serial output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| isp_rst | input | 1 | Programming mode pin; high leaves programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |
| isp_active | output | 1 | High while programming mode is enabled |

## Verification
The bench builds the block with 4-word pages, 4 pages and 8 data bytes. This is small enough that every program word is written and read back in both halves, and every data byte is read back, both after writes and after chip erase. The busy time is set to 700 clocks, which is a little longer than one 528-clock frame. The frame sent straight after a write therefore lands inside the busy window and the next frame lands outside it, so both the masked read and the ignored write can be observed at the pins.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_PROG   = 8'hAC;
  localparam logic [7:0] SUB_EN    = 8'h53;
  localparam logic [7:0] SUB_ERASE = 8'h80;
  localparam logic [7:0] OP_LD_LO  = 8'h40;
  localparam logic [7:0] OP_LD_HI  = 8'h48;
  localparam logic [7:0] OP_COMMIT = 8'h4C;
  localparam logic [7:0] OP_RD_LO  = 8'h20;
  localparam logic [7:0] OP_RD_HI  = 8'h28;
  localparam logic [7:0] OP_EE_WR  = 8'hC0;
  localparam logic [7:0] OP_EE_RD  = 8'hA0;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ERASE, CMD_LD_LO, CMD_LD_HI, CMD_COMMIT, CMD_EE_WR
  } cmd_e;
endpackage

// File: rtl/isp_sck_front.sv
module isp_sck_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic mode_pin,
  output logic rise,
  output logic fall,
  output logic mosi_s,
  output logic clr
);
  logic [SYNC-1:0] sck_q, mosi_q, mode_q;
  logic sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      mode_q <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC-2:0], sck};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      mode_q <= {mode_q[SYNC-2:0], mode_pin};
      sck_d  <= sck_q[SYNC-1];
    end
  end

  assign rise   = sck_q[SYNC-1] & ~sck_d;
  assign fall   = ~sck_q[SYNC-1] & sck_d;
  assign mosi_s = mosi_q[SYNC-1];
  assign clr    = mode_q[SYNC-1];
endmodule

// File: rtl/isp_frame_shifter.sv
module isp_frame_shifter #(
  parameter int BYTES = 4,
  localparam int FBITS = BYTES * 8,
  localparam int CW = $clog2(FBITS),
  localparam int IW = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rise,
  input  logic             fall,
  input  logic             mosi_s,
  input  logic [7:0]       tx_next,
  output logic [FBITS-1:0] frame,
  output logic             byte_done,
  output logic             frame_done,
  output logic [IW-1:0]    next_idx,
  output logic             miso
);
  logic [CW-1:0] bitcnt;
  logic [7:0]    tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0; bitcnt <= '0; byte_done <= 1'b0; tx <= '0; miso <= 1'b0;
    end else if (clr) begin
      frame <= '0; bitcnt <= '0; byte_done <= 1'b0; tx <= '0; miso <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        frame     <= {frame[FBITS-2:0], mosi_s};
        bitcnt    <= bitcnt + 1'b1;
        byte_done <= (bitcnt[2:0] == 3'd7);
      end
      if (byte_done) begin
        tx <= tx_next;
      end else if (fall) begin
        miso <= tx[7];
        tx   <= {tx[6:0], 1'b0};
      end
    end
  end

  assign frame_done = byte_done && (bitcnt == '0);
  assign next_idx   = bitcnt[CW-1:3];

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !clr) |=> $stable(miso)); // R2
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bitcnt == '0 && !byte_done && !miso)); // R11
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rise)); // R1
endmodule

// File: rtl/isp_mem_model.sv
module isp_mem_model
  import isp_pkg::*;
#(
  parameter int PAGE_BITS     = 3,
  parameter int PAGE_CNT_BITS = 3,
  parameter int EE_BITS       = 5,
  parameter int BUSY_CYCLES   = 200,
  localparam int WA    = PAGE_BITS + PAGE_CNT_BITS,
  localparam int WORDS = 1 << WA,
  localparam int PW    = 1 << PAGE_BITS,
  localparam int EEN   = 1 << EE_BITS,
  localparam int BCW   = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cmd_e                     cmd_op,
  input  logic [PAGE_CNT_BITS-1:0] cmd_page,
  input  logic [PAGE_BITS-1:0]     cmd_slot,
  input  logic [EE_BITS-1:0]       cmd_ee,
  input  logic [7:0]               cmd_data,
  input  logic [WA-1:0]            rd_word,
  input  logic                     rd_hi,
  input  logic [EE_BITS-1:0]       rd_ee,
  output logic [7:0]               flash_byte,
  output logic [7:0]               ee_byte,
  output logic                     busy
);
  logic [15:0] flash [WORDS];
  logic [15:0] pbuf  [PW];
  logic [7:0]  ee    [EEN];
  logic [BCW-1:0] busy_cnt;
  logic [PAGE_CNT_BITS-1:0] busy_pg;
  logic pg_flag;

  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) flash[i] <= 16'hFFFF;
      for (int i = 0; i < PW; i++)    pbuf[i]  <= 16'hFFFF;
      for (int i = 0; i < EEN; i++)   ee[i]    <= 8'hFF;
      busy_cnt <= '0;
      busy_pg  <= '0;
      pg_flag  <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (!busy) begin
        case (cmd_op)
          CMD_ERASE: begin
            for (int i = 0; i < WORDS; i++) flash[i] <= 16'hFFFF;
            for (int i = 0; i < EEN; i++)   ee[i]    <= 8'hFF;
            busy_cnt <= BCW'(BUSY_CYCLES);
            pg_flag  <= 1'b0;
          end
          CMD_LD_LO: pbuf[cmd_slot][7:0]  <= cmd_data;
          CMD_LD_HI: pbuf[cmd_slot][15:8] <= cmd_data;
          CMD_COMMIT: begin
            for (int i = 0; i < PW; i++) begin
              flash[{cmd_page, PAGE_BITS'(i)}] <= pbuf[i];
              pbuf[i] <= 16'hFFFF;
            end
            busy_cnt <= BCW'(BUSY_CYCLES);
            busy_pg  <= cmd_page;
            pg_flag  <= 1'b1;
          end
          CMD_EE_WR: begin
            ee[cmd_ee] <= cmd_data;
            busy_cnt   <= BCW'(BUSY_CYCLES);
            pg_flag    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  logic [15:0] word_q;
  assign word_q = flash[rd_word];

  always_comb begin
    if (busy && pg_flag && (rd_word[WA-1:PAGE_BITS] == busy_pg))
      flash_byte = 8'hFF;
    else
      flash_byte = rd_hi ? word_q[15:8] : word_q[7:0];
  end
  assign ee_byte = ee[rd_ee];

  AST_BUSY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_COMMIT && !busy) |=> busy); // R7
  AST_BUSY_HOLDS_EE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ee[0])); // R7
  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_ERASE && !busy) |=> (flash[0] == 16'hFFFF && ee[EEN-1] == 8'hFF)); // R9
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int PAGE_BITS     = 3,
  parameter int PAGE_CNT_BITS = 3,
  parameter int EE_BITS       = 5,
  parameter int BUSY_CYCLES   = 200,
  localparam int WA = PAGE_BITS + PAGE_CNT_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic isp_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic isp_active
);
  logic rise, fall, mosi_s, clr;
  logic [31:0] frame;
  logic byte_done, frame_done;
  logic [1:0] next_idx;
  logic [7:0] tx_next, flash_byte, ee_byte;
  logic busy, active;
  cmd_e cmd_op;
  logic unused_bits;

  isp_sck_front #(.SYNC(2)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .mode_pin(isp_rst),
    .rise(rise), .fall(fall), .mosi_s(mosi_s), .clr(clr)
  );

  isp_frame_shifter #(.BYTES(4)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise), .fall(fall),
    .mosi_s(mosi_s), .tx_next(tx_next), .frame(frame), .byte_done(byte_done),
    .frame_done(frame_done), .next_idx(next_idx), .miso(miso)
  );

  isp_mem_model #(
    .PAGE_BITS(PAGE_BITS), .PAGE_CNT_BITS(PAGE_CNT_BITS),
    .EE_BITS(EE_BITS), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op),
    .cmd_page(frame[8+WA-1:8+PAGE_BITS]), .cmd_slot(frame[8+PAGE_BITS-1:8]),
    .cmd_ee(frame[8+EE_BITS-1:8]), .cmd_data(frame[7:0]),
    .rd_word(frame[WA-1:0]), .rd_hi(frame[23:16] == OP_RD_HI),
    .rd_ee(frame[EE_BITS-1:0]), .flash_byte(flash_byte), .ee_byte(ee_byte),
    .busy(busy)
  );

  assign unused_bits = ^{frame, byte_done};

  // Command decode when the 32nd bit has landed
  always_comb begin
    cmd_op = CMD_NONE;
    if (frame_done && active) begin
      case (frame[31:24])
        OP_PROG:   if (frame[23:16] == SUB_ERASE) cmd_op = CMD_ERASE;
        OP_LD_LO:  cmd_op = CMD_LD_LO;
        OP_LD_HI:  cmd_op = CMD_LD_HI;
        OP_COMMIT: cmd_op = CMD_COMMIT;
        OP_EE_WR:  cmd_op = CMD_EE_WR;
        default:   cmd_op = CMD_NONE;
      endcase
    end
  end

  // Byte to shift out during the next slot
  always_comb begin
    tx_next = frame[7:0];
    if (next_idx == 2'd0) begin
      tx_next = 8'h00;
    end else if (next_idx == 2'd3 && active) begin
      case (frame[23:16])
        OP_RD_LO, OP_RD_HI: tx_next = flash_byte;
        OP_EE_RD:           tx_next = ee_byte;
        default:            tx_next = frame[7:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active <= 1'b0;
    else if (clr)     active <= 1'b0;
    else if (frame_done && frame[31:24] == OP_PROG && frame[23:16] == SUB_EN)
      active <= 1'b1;
  end
  assign isp_active = active;

  AST_ENABLE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isp_active) |-> $past(frame_done)); // R3
  AST_MODE_PIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !isp_active); // R11
endmodule

// File: tb/isp_target_test.sv
module isp_target_test;
  localparam int PB = 2, PCB = 2, EB = 3, BUSY = 700, HALF = 8;
  localparam int WORDS = 1 << (PB + PCB), PW = 1 << PB, EEN = 1 << EB;

  logic clk = 1'b0, rst_n = 1'b0, isp_rst = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, isp_active;
  int nchk = 0, nerr = 0;
  logic [15:0] fm [WORDS];
  logic [7:0]  em [EEN];

  always #10 clk = ~clk;

  isp_target #(.PAGE_BITS(PB), .PAGE_CNT_BITS(PCB), .EE_BITS(EB), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .isp_rst(isp_rst), .sck(sck), .mosi(mosi),
    .miso(miso), .isp_active(isp_active)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, input int nb, output logic [31:0] r);
    r = '0;
    for (int i = 31; i > 31 - nb; i--) begin
      mosi = f[i];
      tick(HALF);
      r[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(16);
  endtask

  task automatic rdf(input int w, input bit hi, output logic [7:0] b);
    logic [31:0] r;
    xfer({hi ? 8'h28 : 8'h20, 8'h00, 8'(w), 8'h00}, 32, r);
    b = r[7:0];
  endtask

  task automatic rde(input int a, output logic [7:0] b);
    logic [31:0] r;
    xfer({8'hA0, 8'h00, 8'(a), 8'h00}, 32, r);
    b = r[7:0];
  endtask

  function automatic logic [15:0] dat(input int w);
    return 16'((w * 16'h1357) ^ 16'hA5C3);
  endfunction

  function automatic logic [7:0] edat(input int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0] b;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R12 mode flag after reset", 32'(isp_active), 0);
    chk("R12 serial out after reset", 32'(miso), 0);
    isp_rst = 1'b0;
    tick(5);

    // Before enable: read acts as echo only
    xfer(32'h20_00_01_00, 32, r);
    chk("R2 echo pattern outside mode", r, 32'h00_20_00_01);
    chk("R3 read does not enable", 32'(isp_active), 0);
    xfer(32'hAC_52_00_00, 32, r);
    chk("R3 bad sync byte stays out", 32'(isp_active), 0);
    chk("R2 echo of bad enable", r, 32'h00_AC_52_00);
    xfer(32'hAC_53_00_00, 32, r);
    chk("R2 enable echoes sync byte", r, 32'h00_AC_53_00);
    chk("R3 enable sets mode", 32'(isp_active), 1);

    for (int w = 0; w < WORDS; w++) fm[w] = 16'hFFFF;
    for (int a = 0; a < EEN; a++) em[a] = 8'hFF;
    rdf(5, 1'b0, b);
    chk("R12 program memory erased at reset", 32'(b), 32'hFF);
    rde(6, b);
    chk("R12 data memory erased at reset", 32'(b), 32'hFF);

    // Stage and commit every page
    for (int p = 0; p < WORDS / PW; p++) begin
      for (int s = 0; s < PW; s++) begin
        logic [15:0] d;
        d = dat(p * PW + s);
        xfer({8'h40, 8'h00, 8'(s), d[7:0]}, 32, r);
        xfer({8'h48, 8'h00, 8'(s), d[15:8]}, 32, r);
        fm[p * PW + s] = d;
      end
      xfer({8'h4C, 8'h00, 8'(p * PW), 8'h00}, 32, r);
      rdf(p * PW + 1, 1'b0, b);
      chk("R8 busy page reads FF", 32'(b), 32'hFF);
      tick(BUSY);
    end

    for (int w = 0; w < WORDS; w++) begin
      rdf(w, 1'b0, b);
      chk("R6 R4 R5 low byte read back", 32'(b), 32'(fm[w][7:0]));
      rdf(w, 1'b1, b);
      chk("R6 R4 R5 high byte read back", 32'(b), 32'(fm[w][15:8]));
    end

    // Commit an unloaded buffer to the last page; other pages stay readable while busy
    xfer({8'h4C, 8'h00, 8'((WORDS / PW - 1) * PW), 8'h00}, 32, r);
    rdf(0, 1'b0, b);
    chk("R8 other page readable while busy", 32'(b), 32'(fm[0][7:0]));
    tick(BUSY);
    for (int s = 0; s < PW; s++) fm[(WORDS / PW - 1) * PW + s] = 16'hFFFF;
    for (int s = 0; s < PW; s++) begin
      rdf((WORDS / PW - 1) * PW + s, 1'b1, b);
      chk("R5 buffer refilled with FF after commit", 32'(b), 32'hFF);
    end

    // Data memory writes
    for (int a = 0; a < EEN; a++) begin
      xfer({8'hC0, 8'h00, 8'(a), edat(a)}, 32, r);
      em[a] = edat(a);
      tick(BUSY);
    end
    for (int a = 0; a < EEN; a++) begin
      rde(a, b);
      chk("R10 data byte read back", 32'(b), 32'(em[a]));
    end
    xfer({8'hC0, 8'h00, 8'd2, 8'h0F}, 32, r);
    tick(BUSY);
    xfer({8'hC0, 8'h00, 8'd2, 8'hF0}, 32, r);
    tick(BUSY);
    em[2] = 8'hF0;
    rde(2, b);
    chk("R10 write replaces old byte", 32'(b), 32'hF0);

    // Writes issued while busy are dropped
    xfer({8'hC0, 8'h00, 8'd3, 8'h55}, 32, r);
    xfer({8'hC0, 8'h00, 8'd4, 8'hAA}, 32, r);
    tick(BUSY);
    em[3] = 8'h55;
    rde(4, b);
    chk("R7 write during busy ignored", 32'(b), 32'(em[4]));
    rde(3, b);
    chk("R7 first write kept", 32'(b), 32'h55);

    // Mode pin mid-frame
    xfer(32'hAC_53_00_00, 12, r);
    isp_rst = 1'b1;
    tick(10);
    chk("R11 mode pin drops mode", 32'(isp_active), 0);
    chk("R11 serial out low", 32'(miso), 0);
    isp_rst = 1'b0;
    tick(10);
    xfer(32'h20_00_01_00, 32, r);
    chk("R11 R1 fresh framing, read inert", r, 32'h00_20_00_01);
    xfer(32'hAC_53_00_00, 32, r);
    chk("R11 re-enable echo", r, 32'h00_AC_53_00);
    rdf(1, 1'b0, b);
    chk("R11 reads work after re-enable", 32'(b), 32'(fm[1][7:0]));

    // Undecoded frame changes nothing
    xfer(32'h77_00_00_12, 32, r);
    tick(BUSY);
    rde(0, b);
    chk("R1 unknown frame is inert", 32'(b), 32'(em[0]));

    // Chip erase
    xfer(32'hAC_80_00_00, 32, r);
    tick(BUSY);
    for (int w = 0; w < WORDS; w++) begin
      rdf(w, 1'b0, b);
      chk("R9 program low erased", 32'(b), 32'hFF);
      rdf(w, 1'b1, b);
      chk("R9 program high erased", 32'(b), 32'hFF);
    end
    for (int a = 0; a < EEN; a++) begin
      rde(a, b);
      chk("R9 data erased", 32'(b), 32'hFF);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule